// File: doc/BRIEF.md
# Cascadable Serial Sample Readout Chain

This block is the digital readout side of a four-channel sampler that can be daisy-chained with identical devices on one serial bus. On a conversion strobe it captures four 24-bit channel samples into a shadow bank and raises a local ready flag. The host lowers chip select and toggles the serial clock. The device that owns the bus shifts its 96 bits out, MSB first, channel 0 first. Each new bit appears after a falling serial clock edge, so the host can sample on the rising edge.

Once its last bit has been shifted, the device lowers its cascade output. The next device, whose cascade input is wired to that output, then takes over the shared data line without a gap. Two devices therefore give one continuous 192-bit frame. The ready outputs are active low and are chained in the same way. A device pulls its ready output low only when its own data is pending and its upstream neighbour reports ready. The first device has both its cascade input and its ready input tied low.

All inputs are synchronous to `clk_i`. Serial clock and chip select edges are detected in that domain, and the serial clock must run slower than `clk_i`. The pad driver for the data line is external: `sdo_oe_o` is its enable.

Top module: `sample_readout_chain`

## Requirements
- R1: A high `conv_i` at a clock edge stores `sample_i` into the shadow bank and sets the local ready flag. The flag clears at the edge where this device shifts out its last own bit. If `conv_i` is high at that same edge, the flag stays set.
- R2: `drdy_no` is low exactly when the local flag is set and `drdy_ni` is low. Otherwise it is high.
- R3: A frame carries 96 bits. Channel k is taken from `sample_i[24*k +: 24]`. Channels go out in the order 0, 1, 2, 3, each MSB first.
- R4: The output bit changes only in the clock cycle after a falling `sclk_i` edge is seen while the device owns the bus. It stays stable while `sclk_i` is high.
- R5: The device owns the bus when all of these hold: chip select has been low for at least one clock, `casc_ni` is low, and its own bits are not finished. `sdo_oe_o` is high only while it owns the bus, and `sdo_o` is 0 when it does not.
- R6: `casc_no` goes low right after the falling edge that completes the 96th own bit. It returns high one clock after `cs_ni` goes high.
- R7: Raising `cs_ni` in the middle of a frame aborts it. The next chip-select window restarts at channel 0 MSB.
- R8: The shift register is loaded from the shadow bank on the falling edge of `cs_ni`. A conversion during a read does not alter the frame in progress. A conversion in the same cycle as the `cs_ni` fall puts the previous words into that frame.
- R9: Two chained devices produce one continuous 192-bit frame, first device first, with never more than one output enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | Conversion strobe; captures samples |
| sample_i | input | 96 | Four 24-bit samples, channel k at [24k+23:24k] |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| casc_ni | input | 1 | Cascade grant from upstream; low = may drive |
| casc_no | output | 1 | Cascade grant to downstream; low = own bits done |
| drdy_ni | input | 1 | Upstream ready, active low |
| drdy_no | output | 1 | Chained ready, active low |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data line pad |

## Verification
Two pairs of functions can meet in one cycle. First, a conversion strobe can arrive in the same cycle that chip select falls. Second, a conversion strobe can arrive at the edge where the last own bit is shifted, so the flag set and the flag clear collide. The bench raises `conv_i` at exactly those edges, with new sample words. It expects the first frame to carry the old words and the next frame the new ones. It also expects the ready output to stay low after the colliding completion, while a plain completion releases it to high.

// File: rtl/readout_pkg.sv
package readout_pkg;
  localparam int unsigned DEF_CH_NUM   = 4;
  localparam int unsigned DEF_SAMPLE_W = 24;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/serial_edge_det.sv
module serial_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  output logic sclk_fall_o,
  output logic cs_fall_o,
  output logic cs_held_o
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
    end
  end

  assign sclk_fall_o = sclk_q & ~sclk_i;
  assign cs_fall_o   = cs_q & ~cs_ni;
  // chip select low for at least one full clock
  assign cs_held_o   = ~cs_q & ~cs_ni;
endmodule

// File: rtl/sample_bank.sv
module sample_bank #(
  parameter int unsigned CH_NUM   = readout_pkg::DEF_CH_NUM,
  parameter int unsigned SAMPLE_W = readout_pkg::DEF_SAMPLE_W,
  localparam int unsigned FRAME_W = CH_NUM * SAMPLE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               conv_i,
  input  logic [FRAME_W-1:0] sample_i,
  input  logic               done_set_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               ready_o
);
  logic [SAMPLE_W-1:0] shadow_q [CH_NUM];
  logic                flag_q;

  for (genvar k = 0; k < CH_NUM; k++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     shadow_q[k] <= '0;
      else if (conv_i) shadow_q[k] <= sample_i[k*SAMPLE_W +: SAMPLE_W];
    end
    // channel 0 lands in the top slice so it leaves first
    assign frame_o[(CH_NUM-1-k)*SAMPLE_W +: SAMPLE_W] = shadow_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (conv_i)     flag_q <= 1'b1;  // new data beats completion
    else if (done_set_i) flag_q <= 1'b0;
  end

  assign ready_o = flag_q;

  assert_flag_on_conv_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_i |=> flag_q);
  assert_flag_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_set_i && !conv_i) |=> !flag_q);
endmodule

// File: rtl/shift_engine.sv
module shift_engine #(
  parameter int unsigned BITS = 96,
  localparam int unsigned CW  = readout_pkg::cnt_width(BITS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            load_i,
  input  logic [BITS-1:0] frame_i,
  input  logic            shift_i,
  output logic            bit_o,
  output logic            done_o,
  output logic            done_set_o
);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [BITS-1:0] shreg_q;
  logic [CW-1:0]   cnt_q;
  logic            done_q;

  assign done_set_o = shift_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (load_i) begin
      shreg_q <= frame_i;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (shift_i) begin
      shreg_q <= {shreg_q[BITS-2:0], 1'b0};
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign bit_o  = shreg_q[BITS-1];
  assign done_o = done_q;

  assert_hold_without_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(shreg_q));
  assert_no_shift_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !shift_i);
endmodule

// File: rtl/sample_readout_chain.sv
module sample_readout_chain #(
  parameter int unsigned CH_NUM   = readout_pkg::DEF_CH_NUM,
  parameter int unsigned SAMPLE_W = readout_pkg::DEF_SAMPLE_W,
  localparam int unsigned FRAME_W = CH_NUM * SAMPLE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               conv_i,
  input  logic [FRAME_W-1:0] sample_i,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               casc_ni,
  output logic               casc_no,
  input  logic               drdy_ni,
  output logic               drdy_no,
  output logic               sdo_o,
  output logic               sdo_oe_o
);
  logic sclk_fall, cs_fall, cs_held;
  logic own, done, done_set, bit_out, ready;
  logic [FRAME_W-1:0] frame;

  serial_edge_det u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .cs_ni       (cs_ni),
    .sclk_fall_o (sclk_fall),
    .cs_fall_o   (cs_fall),
    .cs_held_o   (cs_held)
  );

  sample_bank #(.CH_NUM(CH_NUM), .SAMPLE_W(SAMPLE_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_i     (conv_i),
    .sample_i   (sample_i),
    .done_set_i (done_set),
    .frame_o    (frame),
    .ready_o    (ready)
  );

  assign own = cs_held & ~casc_ni & ~done;

  shift_engine #(.BITS(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (cs_ni),
    .load_i     (cs_fall),
    .frame_i    (frame),
    .shift_i    (own & sclk_fall),
    .bit_o      (bit_out),
    .done_o     (done),
    .done_set_o (done_set)
  );

  assign sdo_oe_o = own;
  assign sdo_o    = own & bit_out;
  assign casc_no  = ~done;
  assign drdy_no  = ~(ready & ~drdy_ni);

  assert_oe_needs_select_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> (!cs_ni && !casc_ni));
  assert_quiet_when_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);
  assert_casc_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> casc_no);
  assert_ready_chain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drdy_no |-> !drdy_ni);
endmodule

// File: tb/sample_readout_chain_test.sv
module sample_readout_chain_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 24;
  localparam int CH = 4;
  localparam int FB = W * CH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_a = 1'b0, conv_b = 1'b0;
  logic [FB-1:0] smp_a = '0, smp_b = '0;
  logic cs_n = 1'b1, sclk = 1'b0;
  logic casc_a, casc_b, drdy_a, drdy_b;
  logic sdo_a, sdo_b, oe_a, oe_b;

  int checks = 0, fails = 0;
  int contention = 0, float_cnt = 0, unstable = 0;
  logic [2*FB-1:0] rx;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_readout_chain uut (
    .clk_i(clk), .rst_ni(rst_n), .conv_i(conv_a), .sample_i(smp_a),
    .cs_ni(cs_n), .sclk_i(sclk), .casc_ni(1'b0), .casc_no(casc_a),
    .drdy_ni(1'b0), .drdy_no(drdy_a), .sdo_o(sdo_a), .sdo_oe_o(oe_a)
  );

  sample_readout_chain nxt_dev (
    .clk_i(clk), .rst_ni(rst_n), .conv_i(conv_b), .sample_i(smp_b),
    .cs_ni(cs_n), .sclk_i(sclk), .casc_ni(casc_a), .casc_no(casc_b),
    .drdy_ni(drdy_a), .drdy_no(drdy_b), .sdo_o(sdo_b), .sdo_oe_o(oe_b)
  );

  function automatic logic [FB-1:0] exp_frame(input logic [FB-1:0] s);
    logic [FB-1:0] f = '0;
    for (int c = 0; c < CH; c++)
      for (int b = W-1; b >= 0; b--)
        f = {f[FB-2:0], s[c*W + b]};
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [2*FB-1:0] act,
                     input logic [2*FB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic convert_a(input logic [FB-1:0] s);
    @(negedge clk); smp_a = s; conv_a = 1'b1;
    @(negedge clk); conv_a = 1'b0;
  endtask

  task automatic convert_b(input logic [FB-1:0] s);
    @(negedge clk); smp_b = s; conv_b = 1'b1;
    @(negedge clk); conv_b = 1'b0;
  endtask

  task automatic select;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic deselect;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  // host: sample on rising sclk; optional conversion on the last falling edge
  task automatic shift_bits(input int n, input bit conv_last);
    for (int i = 0; i < n; i++) begin
      logic b;
      @(negedge clk);
      if (oe_a && oe_b) contention++;
      if (!oe_a && !oe_b) float_cnt++;
      b = oe_a ? sdo_a : sdo_b;
      rx = {rx[2*FB-2:0], b};
      sclk = 1'b1;
      @(negedge clk);
      if ((oe_a ? sdo_a : sdo_b) !== b) unstable++;
      @(negedge clk);
      sclk = 1'b0;
      if (conv_last && i == n-1) conv_a = 1'b1;
      @(negedge clk);
      conv_a = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(drdy_a === 1'b1 && drdy_b === 1'b1, "R2 reset ready high", {drdy_a, drdy_b}, 2'b11);
    chk(casc_a === 1'b1 && casc_b === 1'b1, "R6 reset cascade high", {casc_a, casc_b}, 2'b11);
    chk(oe_a === 1'b0 && oe_b === 1'b0 && sdo_a === 1'b0, "R5 reset bus released",
        {oe_a, oe_b, sdo_a}, 3'b000);
  endtask

  task automatic t_ready_chain(input logic [FB-1:0] a, input logic [FB-1:0] b);
    convert_b(b);
    @(negedge clk);
    chk(drdy_b === 1'b1, "R2 downstream waits for upstream", drdy_b, 1'b1);
    convert_a(a);
    @(negedge clk);
    chk(drdy_a === 1'b0, "R1 conversion sets ready", drdy_a, 1'b0);
    chk(drdy_b === 1'b0, "R2 both ready chains low", drdy_b, 1'b0);
  endtask

  task automatic t_two_devices(input logic [FB-1:0] a, input logic [FB-1:0] b);
    rx = '0; contention = 0; float_cnt = 0; unstable = 0;
    select();
    shift_bits(FB, 1'b0);
    chk(casc_a === 1'b0 && oe_a === 1'b0, "R6 cascade low after own bits", {casc_a, oe_a}, 2'b00);
    chk(drdy_a === 1'b1, "R1 ready clears after own bits", drdy_a, 1'b1);
    shift_bits(FB, 1'b0);
    chk(rx === {exp_frame(a), exp_frame(b)}, "R9 192-bit frame", rx, {exp_frame(a), exp_frame(b)});
    chk(rx[2*FB-1:FB] === exp_frame(a), "R3 channel order MSB first", rx[2*FB-1:FB], exp_frame(a));
    chk(contention == 0 && float_cnt == 0, "R9 single driver per bit",
        contention * 1000 + float_cnt, 0);
    chk(unstable == 0, "R4 data stable while sclk high", unstable, 0);
    chk(drdy_b === 1'b1 && casc_b === 1'b0, "R1 downstream done", {drdy_b, casc_b}, 2'b10);
    deselect();
    chk(casc_a === 1'b1 && casc_b === 1'b1, "R6 cascade released by cs", {casc_a, casc_b}, 2'b11);
    chk(oe_a === 1'b0 && oe_b === 1'b0, "R5 no driver with cs high", {oe_a, oe_b}, 2'b00);
  endtask

  task automatic t_abort(input logic [FB-1:0] a);
    select();
    shift_bits(40, 1'b0);
    deselect();
    rx = '0;
    select();
    shift_bits(FB, 1'b0);
    deselect();
    chk(rx[FB-1:0] === exp_frame(a), "R7 restart after abort", rx[FB-1:0], exp_frame(a));
  endtask

  task automatic t_shadow(input logic [FB-1:0] a, input logic [FB-1:0] c);
    rx = '0;
    select();
    shift_bits(30, 1'b0);
    convert_a(c);
    shift_bits(FB-30, 1'b0);
    deselect();
    chk(rx[FB-1:0] === exp_frame(a), "R8 frame kept during conversion", rx[FB-1:0], exp_frame(a));
    rx = '0;
    select();
    shift_bits(FB, 1'b0);
    deselect();
    chk(rx[FB-1:0] === exp_frame(c), "R8 new words next frame", rx[FB-1:0], exp_frame(c));
  endtask

  task automatic t_conv_at_select(input logic [FB-1:0] c, input logic [FB-1:0] d);
    rx = '0;
    @(negedge clk); cs_n = 1'b0; smp_a = d; conv_a = 1'b1;
    @(negedge clk); conv_a = 1'b0;
    @(negedge clk);
    shift_bits(FB, 1'b0);
    deselect();
    chk(rx[FB-1:0] === exp_frame(c), "R8 conv at cs fall keeps old words", rx[FB-1:0], exp_frame(c));
    rx = '0;
    select();
    shift_bits(FB, 1'b1);
    chk(rx[FB-1:0] === exp_frame(d), "R8 conv at cs fall lands next frame", rx[FB-1:0], exp_frame(d));
    chk(drdy_a === 1'b0, "R1 conv at completion keeps ready", drdy_a, 1'b0);
    chk(oe_a === 1'b0 && casc_a === 1'b0, "R5 released after completion", {oe_a, casc_a}, 2'b00);
    deselect();
  endtask

  initial begin
    logic [FB-1:0] wa, wb, wc, wd;
    wa = {24'hA1B2C3, 24'h5A5A5A, 24'h00FF01, 24'h800001};
    wb = {24'h123456, 24'hFEDCBA, 24'h0F0F0F, 24'hC00003};
    wc = {24'h7FFFFF, 24'h000000, 24'hFFFFFF, 24'h2468AC};
    wd = {24'h13579B, 24'hDEAD01, 24'h3C3C3C, 24'h010101};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ready_chain(wa, wb);
    t_two_devices(wa, wb);
    t_abort(wa);
    t_shadow(wa, wc);
    t_conv_at_select(wc, wd);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule